// File: doc/BRIEF.md
# Error Status Bit Serializer

This block carries six bus-error status flags to neighbouring logic over one wire. A single active-low select input picks what that wire means. While the select is high, the wire shows a summary: it is set when any flag is set whose enable bit in a six-bit mask is also set. While the select is low, the wire shows the flags one by one, in a fixed order, and moves to the next flag on each rising edge of the bus clock.

At the first clock edge with the select low, the block takes a snapshot of all six flags. The rest of the readout comes from that snapshot, so flags that change mid-readout do not corrupt the sequence. After the last flag the wire stays low until the select goes high again. Driving the select high at any time clears the bit pointer, so the next low period starts again at the first flag.

Everything runs on the bus clock. The output is registered, and there is a synchronous active-high reset.

Top module: `errstat_serializer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `stat_o` is 0 after that edge, whatever the other inputs are.
- R2: At an edge where `serial_sel_n` is 1, `stat_o` becomes the OR over i of (`flags_i[i]` AND `mask_i[i]`), using the values sampled at that edge.
- R3: In serial mode the mask has no effect: the bits shifted out are the raw flag values, even when the mask bit is 0.
- R4: At the first edge with `serial_sel_n` at 0 after it was 1 (or after reset), `stat_o` becomes `flags_i[0]` (detected parity error), and all six flags are captured at that edge.
- R5: At edges 2 to 6 of a low period, `stat_o` presents captured bits 1 to 5 in order: bit 1 signaled system error, bit 2 received master abort, bit 3 received target abort, bit 4 signaled target abort, bit 5 master data parity error.
- R6: Changes on `flags_i` after the capture edge do not alter the bits shifted out in that low period.
- R7: From edge 7 of a low period onward, `stat_o` is 0 until `serial_sel_n` returns to 1.
- R8: A single edge with `serial_sel_n` at 1 resets the pointer, so the next low period restarts at bit 0 with a new capture, even if the previous readout was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flags_i | input | 6 | Raw status flags, bit order as in R5 |
| mask_i | input | 6 | Per-flag enable for the summary |
| serial_sel_n | input | 1 | 1 = summary mode, 0 = serial mode |
| stat_o | output | 1 | Registered status line |

## Verification
The summary is driven with random flag and mask pairs. These include pairs where the only set flags are masked off, which separates a masked OR from a raw OR. Serial readouts are run with the flags changing randomly on every cycle. This separates a snapshot from a live tap and shows whether the mask leaks into serial mode. Readouts of random length, from a single cycle to well past six, test the idle-low tail and show whether a short high pulse fully restarts the pointer. A directed walking-one pattern checks each bit position in order, which exposes any swapped or shifted index.

// File: rtl/errstat_pkg.sv
package errstat_pkg;
  localparam int unsigned ERR_COUNT = 6;

  // Bit positions set the serial readout order.
  typedef enum int unsigned {
    ERR_DET_PAR  = 0,
    ERR_SIG_SYS  = 1,
    ERR_RCV_MABT = 2,
    ERR_RCV_TABT = 3,
    ERR_SIG_TABT = 4,
    ERR_MST_DPAR = 5
  } err_idx_e;
endpackage

// File: rtl/errstat_summary.sv
module errstat_summary #(
  parameter int unsigned N_FLAGS = errstat_pkg::ERR_COUNT
) (
  input  logic [N_FLAGS-1:0] flags_i,
  input  logic [N_FLAGS-1:0] mask_i,
  output logic               any_o
);
  logic [N_FLAGS-1:0] gated;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_gate
    assign gated[g] = flags_i[g] & mask_i[g];
  end

  assign any_o = |gated;
endmodule

// File: rtl/errstat_sequencer.sv
module errstat_sequencer #(
  parameter int unsigned N_FLAGS = errstat_pkg::ERR_COUNT,
  parameter int unsigned PTR_W   = $clog2(N_FLAGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  output logic             first_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(N_FLAGS);

  logic             started_q;
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst || sel_n) begin
      started_q <= 1'b0;
      ptr_q     <= '0;
    end else if (!started_q) begin
      started_q <= 1'b1;
      ptr_q     <= PTR_W'(1);
    end else if (ptr_q != PTR_END) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end
  end

  assign first_o = !sel_n && !started_q;
  assign ptr_o   = ptr_q;

  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> (ptr_q == '0)); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && started_q && ptr_q != PTR_END) |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R5
  AST_PTR_PARKED: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && ptr_q == PTR_END) |=> (ptr_q == PTR_END || ptr_q == '0)); // R7
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PTR_END); // R7
endmodule

// File: rtl/errstat_snapshot.sv
module errstat_snapshot #(
  parameter int unsigned N_FLAGS = errstat_pkg::ERR_COUNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [N_FLAGS-1:0] flags_i,
  output logic [N_FLAGS-1:0] snap_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_o <= '0;
    end else if (load_i) begin
      snap_o <= flags_i;
    end
  end
endmodule

// File: rtl/errstat_serializer.sv
module errstat_serializer #(
  parameter int unsigned N_FLAGS = errstat_pkg::ERR_COUNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_FLAGS-1:0] flags_i,
  input  logic [N_FLAGS-1:0] mask_i,
  input  logic               serial_sel_n,
  output logic               stat_o
);
  localparam int unsigned PTR_W = $clog2(N_FLAGS + 1);

  logic               any_w;
  logic               first_w;
  logic [PTR_W-1:0]   ptr_w;
  logic [N_FLAGS-1:0] snap_w;
  logic               serial_bit;

  errstat_summary #(.N_FLAGS(N_FLAGS)) u_summary (
    .flags_i (flags_i),
    .mask_i  (mask_i),
    .any_o   (any_w)
  );

  errstat_sequencer #(.N_FLAGS(N_FLAGS), .PTR_W(PTR_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .sel_n   (serial_sel_n),
    .first_o (first_w),
    .ptr_o   (ptr_w)
  );

  errstat_snapshot #(.N_FLAGS(N_FLAGS)) u_snap (
    .clk     (clk),
    .rst     (rst),
    .load_i  (first_w),
    .flags_i (flags_i),
    .snap_o  (snap_w)
  );

  // First edge reads the live input; later edges read the snapshot.
  // A pointer past the last index selects nothing and yields 0.
  always_comb begin
    serial_bit = 1'b0;
    if (first_w) begin
      serial_bit = flags_i[errstat_pkg::ERR_DET_PAR];
    end else begin
      for (int i = 0; i < N_FLAGS; i++) begin
        if (ptr_w == PTR_W'(i)) serial_bit = snap_w[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o <= 1'b0;
    end else if (serial_sel_n) begin
      stat_o <= any_w;
    end else begin
      stat_o <= serial_bit;
    end
  end

  AST_RST_LOW: assert property (@(posedge clk)
    rst |=> !stat_o); // R1
  AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (rst)
    serial_sel_n |=> (stat_o == $past(|(flags_i & mask_i)))); // R2
  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
    first_w |=> (stat_o == $past(flags_i[0]))); // R4
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
    (!serial_sel_n && !first_w) |=> $stable(snap_w)); // R6
endmodule

// File: tb/errstat_serializer_tb.sv
module errstat_serializer_tb;
  localparam int NF = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NF-1:0] flags_i = '0;
  logic [NF-1:0] mask_i = '0;
  logic          serial_sel_n = 1'b1;
  logic          stat_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state derived from the requirements
  int            m_cnt = 0;
  logic [NF-1:0] m_snap = '0;

  always #10 clk = ~clk;

  errstat_serializer #(.N_FLAGS(NF)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .flags_i      (flags_i),
    .mask_i       (mask_i),
    .serial_sel_n (serial_sel_n),
    .stat_o       (stat_o)
  );

  function automatic logic summary_ref(logic [NF-1:0] f, logic [NF-1:0] m);
    return |(f & m);
  endfunction

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: stat_o=%0b expected %0b", tag, got, exp);
    end
  endtask

  // Drive one cycle, predict, and compare after the edge.
  task automatic tick(logic [NF-1:0] f, logic [NF-1:0] m, logic s, string tag_in);
    logic  exp;
    string tag;
    @(negedge clk);
    flags_i = f; mask_i = m; serial_sel_n = s;
    if (s) begin
      exp = summary_ref(f, m); m_cnt = 0; tag = "R2";
    end else if (m_cnt == 0) begin
      m_snap = f; exp = f[0]; m_cnt = 1; tag = "R4";
    end else if (m_cnt < NF) begin
      exp = m_snap[m_cnt]; m_cnt++; tag = "R5/R6";
    end else begin
      exp = 1'b0; m_cnt++; tag = "R7";
    end
    if (tag_in != "") tag = tag_in;
    @(posedge clk);
    #2;
    check(tag, stat_o, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset forces the line low even with every flag enabled
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      flags_i = '1; mask_i = '1; serial_sel_n = (i == 1);
      @(posedge clk); #2;
      check("R1", stat_o, 1'b0);
    end
    @(negedge clk); rst = 1'b0; m_cnt = 0;

    // R2: masked-off flags do not raise the summary
    tick(6'b101010, 6'b010101, 1'b1, "R2");
    tick(6'b101010, 6'b100000, 1'b1, "R2");
    tick(6'b000000, 6'b111111, 1'b1, "R2");

    // R4/R5: walking one, each position read in order
    for (int p = 0; p < NF; p++) begin
      tick('0, '1, 1'b1, "R8");
      for (int k = 0; k < NF + 2; k++)
        tick((k == 0) ? NF'(1 << p) : '0, '1, 1'b0, (k == p) ? "R5" : "");
    end

    // R3: mask zero, serial output still shows raw flags
    tick('0, '0, 1'b1, "");
    tick(6'b110101, 6'b000000, 1'b0, "R3");
    for (int k = 1; k < NF; k++) tick(6'b000000, 6'b000000, 1'b0, "R3");

    // R7: long tail stays low
    for (int k = 0; k < 5; k++) tick('1, '1, 1'b0, "R7");

    // R8: cut readout short, one high cycle, restart from bit 0
    tick('0, '1, 1'b1, "");
    tick(6'b000010, '1, 1'b0, "R4");
    tick(6'b000000, '1, 1'b0, "R5");
    tick(6'b000000, '0, 1'b1, "R8");
    tick(6'b000001, '1, 1'b0, "R8");
    tick(6'b000000, '1, 1'b0, "R8");

    // Random mix: summary bursts and serial readouts with churning flags (R6)
    for (int it = 0; it < 400; it++) begin
      int hi_len = 1 + ($urandom % 3);
      int lo_len = 1 + ($urandom % 10);
      for (int k = 0; k < hi_len; k++)
        tick(NF'($urandom), NF'($urandom), 1'b1, "");
      for (int k = 0; k < lo_len; k++)
        tick(NF'($urandom), NF'($urandom), 1'b0, "");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule